// File: doc/BRIEF.md
# Dual-Version Packet Check Unit

This unit produces and verifies the trailing check value of short radio packets of 4, 8, 16 or 32 bytes. Bytes arrive one per cycle, qualified by a valid strobe. A start strobe marks the first byte of a packet and a last strobe marks its final byte. Bits [7:6] of the first byte carry a size code. The unit keeps two running values side by side: a plain XOR of the data bytes and an 8-bit CRC. The two values are forced to differ, so a receiver can tell which protocol generation built a packet.

In generate mode the unit treats every byte fed to it as data and returns the check value to append. In verify mode the byte carrying the last strobe is the received check byte. It is left out of the running values and compared against both forms. For the shortest packet the check value shrinks to a nibble in the low four bits of the final byte. The upper four bits of that byte stay free for payload.

Top module: `pkt_check_unit`

## Requirements
- R1: The size code is taken from bits [7:6] of the byte that carries the start strobe: 00 means a 4-byte packet, 01 means 8, 10 means 16 and 11 means 32. Only code 00 selects the nibble form.
- R2: The legacy form is the XOR of every data byte of the packet, from the start byte through the last data byte.
- R3: The current form is the CRC-8 of the data bytes. It uses polynomial 0x07, shifts most-significant bit first and starts from 0x00.
- R4: When the CRC equals the XOR, the current form is the CRC plus one, modulo 256. This adjustment is applied to the 8-bit values, before any folding.
- R5: For a 4-byte packet, each form folds to the XOR of its high and low nibbles. The folded value appears on chk_value[3:0], with chk_value[7:4] equal to zero.
- R6: Generate mode (verify_mode=0 on the cycle of the last byte): the last byte is data. chk_done pulses in the cycle after that byte, chk_value shows the current form, and legacy_ok and current_ok are 0.
- R7: Verify mode (verify_mode=1 on the cycle of the last byte): the last byte is the received check value and is not accumulated. chk_value shows the current form. current_ok is set when the received value equals the current form, and legacy_ok when it equals the legacy form. A 4-byte packet compares only bits [3:0] of the received byte and ignores bits [7:4].
- R8: A byte carrying the start strobe restarts both running values, discarding any unfinished packet.
- R9: A cycle with byte_valid low has no effect, whatever the start, last and data inputs carry, and produces no chk_done.
- R10: While reset is high, and in the cycle after it, chk_done, chk_value, legacy_ok and current_ok are all 0.
- R11: chk_done is high for exactly one cycle per last byte. The results hold their values until the next chk_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Byte on byte_data is valid this cycle |
| byte_start | input | 1 | First byte of a packet |
| byte_last | input | 1 | Final byte of the packet (check byte in verify mode) |
| byte_data | input | 8 | Packet byte |
| verify_mode | input | 1 | 1 = compare the final byte, 0 = produce a check value |
| chk_done | output | 1 | One-cycle pulse when results are valid |
| chk_value | output | 8 | Current-form check value (nibble in [3:0] for 4-byte packets) |
| legacy_ok | output | 1 | Received value matches the XOR form |
| current_ok | output | 1 | Received value matches the adjusted CRC form |

## Verification
Every result is registered once. chk_done, chk_value and both match flags appear in the cycle after the posedge that captures the byte with the last strobe. They are not valid in the cycle that byte is driven. The bench drives inputs on the falling edge and samples the results on the next falling edge, half a period after the capturing edge. It then samples once more a full cycle later to confirm that the pulse has dropped and the values have held. The idle cycles inserted between bytes are checked at the falling edge that follows them, to confirm that chk_done stays low there.

// File: rtl/pkt_chk_pkg.sv
package pkt_chk_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int SIZE_W   = 2;
    localparam int SIZE_LSB = BYTE_W - SIZE_W;
    localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;
    localparam logic [BYTE_W-1:0] CRC_INIT = 8'h00;

    typedef enum logic [SIZE_W-1:0] {
        PKT_4B  = 2'b00,
        PKT_8B  = 2'b01,
        PKT_16B = 2'b10,
        PKT_32B = 2'b11
    } pkt_size_e;

    typedef struct packed {
        logic [BYTE_W-1:0] xr;
        logic [BYTE_W-1:0] crc;
    } acc_s;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        logic              legacy_ok;
        logic              current_ok;
    } result_s;

    localparam acc_s ACC_INIT = '{xr: '0, crc: CRC_INIT};

    // One byte of CRC, most significant bit first.
    function automatic logic [BYTE_W-1:0] crc_byte(input logic [BYTE_W-1:0] crc_in,
                                                   input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] c;
        c = crc_in ^ d;
        for (int k = 0; k < BYTE_W; k++) begin
            c = c[BYTE_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

    function automatic acc_s acc_step(input acc_s a, input logic [BYTE_W-1:0] d);
        acc_s r;
        r.xr  = a.xr ^ d;
        r.crc = crc_byte(a.crc, d);
        return r;
    endfunction

    // Fold a byte to the XOR of its nibbles, placed in the low half.
    function automatic logic [BYTE_W-1:0] fold_nib(input logic [BYTE_W-1:0] v);
        return {{NIB_W{1'b0}}, v[BYTE_W-1:NIB_W] ^ v[NIB_W-1:0]};
    endfunction

endpackage

// File: rtl/pkt_chk_accum.sv
module pkt_chk_accum
    import pkt_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              restart,
    input  logic [BYTE_W-1:0] data,
    output acc_s              acc_q,
    output acc_s              acc_nxt
);

    acc_s base;

    always_comb begin
        base    = restart ? ACC_INIT : acc_q;
        acc_nxt = acc_step(base, data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= ACC_INIT;
        end else if (take) begin
            acc_q <= acc_nxt;
        end
    end

    assert_acc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(acc_q));

endmodule

// File: rtl/pkt_chk_finalize.sv
module pkt_chk_finalize
    import pkt_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              verify,
    input  logic              short_pkt,
    input  acc_s              acc,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              done,
    output result_s           res
);

    logic [BYTE_W-1:0] leg8, cur8, leg_f, cur_f, rx_m;
    result_s           res_d;
    logic              mode_q, short_q;

    always_comb begin
        leg8  = acc.xr;
        cur8  = (acc.crc == acc.xr) ? acc.crc + 8'd1 : acc.crc;
        leg_f = short_pkt ? fold_nib(leg8) : leg8;
        cur_f = short_pkt ? fold_nib(cur8) : cur8;
        rx_m  = short_pkt ? {{NIB_W{1'b0}}, rx_byte[NIB_W-1:0]} : rx_byte;
        res_d.value      = cur_f;
        res_d.legacy_ok  = verify && (rx_m == leg_f);
        res_d.current_ok = verify && (rx_m == cur_f);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            res     <= '0;
            mode_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            done <= fire;
            if (fire) begin
                res     <= res_d;
                mode_q  <= verify;
                short_q <= short_pkt;
            end
        end
    end

    assert_forms_differ_R4: assert property (@(posedge clk) disable iff (rst)
        fire |-> (cur8 != leg8));

    assert_short_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (done && short_q) |-> (res.value[BYTE_W-1:NIB_W] == '0));

    assert_gen_no_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> (!res.legacy_ok && !res.current_ok));

    assert_hold_between_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(res));

endmodule

// File: rtl/pkt_check_unit.sv
module pkt_check_unit
    import pkt_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic              byte_start,
    input  logic              byte_last,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              verify_mode,
    output logic              chk_done,
    output logic [BYTE_W-1:0] chk_value,
    output logic              legacy_ok,
    output logic              current_ok
);

    pkt_size_e size_q, size_sel;
    acc_s      acc_q, acc_nxt, acc_src;
    result_s   res;
    logic      take, fire, short_pkt;

    always_comb begin
        size_sel  = byte_start ? pkt_size_e'(byte_data[BYTE_W-1:SIZE_LSB]) : size_q;
        short_pkt = (size_sel == PKT_4B);
        fire      = byte_valid && byte_last;
        take      = byte_valid && !(verify_mode && byte_last);
        if (verify_mode) begin
            acc_src = byte_start ? ACC_INIT : acc_q;
        end else begin
            acc_src = acc_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= PKT_4B;
        end else if (byte_valid && byte_start) begin
            size_q <= size_sel;
        end
    end

    pkt_chk_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .restart (byte_start),
        .data    (byte_data),
        .acc_q   (acc_q),
        .acc_nxt (acc_nxt)
    );

    pkt_chk_finalize u_final (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .verify    (verify_mode),
        .short_pkt (short_pkt),
        .acc       (acc_src),
        .rx_byte   (byte_data),
        .done      (chk_done),
        .res       (res)
    );

    assign chk_value  = res.value;
    assign legacy_ok  = res.legacy_ok;
    assign current_ok = res.current_ok;

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!chk_done && chk_value == '0 && !legacy_ok && !current_ok));

    assert_idle_no_done_R9: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && byte_last) |=> !chk_done);

endmodule

// File: tb/pkt_check_unit_bench.sv
module pkt_check_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       byte_valid, byte_start, byte_last, verify_mode;
    logic [7:0] byte_data;
    logic       chk_done, legacy_ok, current_ok;
    logic [7:0] chk_value;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] pkt [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_check_unit u_pkt_check_unit (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_start(byte_start),
        .byte_last(byte_last), .byte_data(byte_data), .verify_mode(verify_mode),
        .chk_done(chk_done), .chk_value(chk_value), .legacy_ok(legacy_ok),
        .current_ok(current_ok)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bit-serial reference model of the spec.
    function automatic logic [7:0] m_crc(input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[7] ^ pkt[i][b];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] m_xor(input int n);
        logic [7:0] x = 8'h00;
        for (int i = 0; i < n; i++) x ^= pkt[i];
        return x;
    endfunction

    function automatic logic [7:0] m_fold(input logic [7:0] v);
        return {4'h0, v[7:4] ^ v[3:0]};
    endfunction

    function automatic logic [7:0] m_cur(input int ndata, input bit shrt);
        logic [7:0] c = m_crc(ndata);
        logic [7:0] x = m_xor(ndata);
        if (c == x) c = c + 8'd1;
        return shrt ? m_fold(c) : c;
    endfunction

    function automatic logic [7:0] m_leg(input int ndata, input bit shrt);
        logic [7:0] x = m_xor(ndata);
        return shrt ? m_fold(x) : x;
    endfunction

    task automatic fill(input int n, input logic [1:0] code);
        for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
        pkt[0][7:6] = code;
    endtask

    // Feeds nfeed bytes; returns at the falling edge after the last byte is captured.
    task automatic feed(input int nfeed, input bit vmode, input bit gaps);
        for (int i = 0; i < nfeed; i++) begin
            @(negedge clk);
            if (gaps && i > 0) begin
                byte_valid = 1'b0; byte_start = 1'b1; byte_last = 1'b1;
                byte_data  = 8'hA5; verify_mode = ~vmode;
                @(negedge clk);
                check("R9 no done on idle cycle", {7'd0, chk_done}, 8'd0);
            end
            byte_valid  = 1'b1;
            byte_start  = (i == 0);
            byte_last   = (i == nfeed - 1);
            byte_data   = pkt[i];
            verify_mode = vmode;
        end
        @(negedge clk);
        byte_valid = 1'b0; byte_start = 1'b0; byte_last = 1'b0;
    endtask

    task automatic expect_res(input string req, input int n, input bit vmode);
        bit shrt = (n == 4);
        logic [7:0] cur = m_cur(n - 1, shrt);
        logic [7:0] leg = m_leg(n - 1, shrt);
        logic [7:0] rx  = shrt ? {4'h0, pkt[n-1][3:0]} : pkt[n-1];
        check({req, " done"}, {7'd0, chk_done}, 8'd1);
        check({req, " value"}, chk_value, cur);
        check({req, " legacy_ok"}, {7'd0, legacy_ok}, {7'd0, vmode && rx == leg});
        check({req, " current_ok"}, {7'd0, current_ok}, {7'd0, vmode && rx == cur});
    endtask

    task automatic test_reset();
        rst = 1'b1; byte_valid = 1'b0; byte_start = 1'b0; byte_last = 1'b0;
        byte_data = 8'h00; verify_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 done", {7'd0, chk_done}, 8'd0);
        check("R10 value", chk_value, 8'd0);
        check("R10 flags", {6'd0, legacy_ok, current_ok}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 done after release", {7'd0, chk_done}, 8'd0);
    endtask

    task automatic test_generate(input int n, input logic [1:0] code);
        fill(n, code);
        feed(n - 1, 1'b0, 1'b0);
        expect_res("R1 R3 R6 generate", n, 1'b0);
    endtask

    task automatic test_verify_large(input int n, input logic [1:0] code);
        fill(n, code);
        pkt[n-1] = m_cur(n - 1, 1'b0);
        feed(n, 1'b1, 1'b0);
        expect_res("R7 verify current", n, 1'b1);
        check("R7 current_ok set", {7'd0, current_ok}, 8'd1);
        pkt[n-1] = m_leg(n - 1, 1'b0);
        feed(n, 1'b1, 1'b0);
        expect_res("R2 verify legacy", n, 1'b1);
        check("R2 legacy_ok set", {7'd0, legacy_ok}, 8'd1);
        pkt[n-1] = m_cur(n - 1, 1'b0) ^ 8'h80;
        if (pkt[n-1] == m_leg(n - 1, 1'b0)) pkt[n-1] ^= 8'h01;
        feed(n, 1'b1, 1'b0);
        expect_res("R7 verify corrupt", n, 1'b1);
    endtask

    task automatic test_short();
        fill(4, 2'b00);
        feed(3, 1'b0, 1'b0);
        expect_res("R5 short generate", 4, 1'b0);
        check("R5 upper nibble zero", {4'h0, chk_value[7:4]}, 8'd0);
        pkt[3] = {4'hC, m_cur(3, 1'b1)[3:0]};
        feed(4, 1'b1, 1'b0);
        expect_res("R7 short verify", 4, 1'b1);
        check("R7 short current_ok", {7'd0, current_ok}, 8'd1);
        pkt[3][7:4] = 4'h3;
        feed(4, 1'b1, 1'b0);
        check("R7 upper nibble ignored", {7'd0, current_ok}, 8'd1);
        pkt[3] = {4'h9, m_leg(3, 1'b1)[3:0]};
        feed(4, 1'b1, 1'b0);
        expect_res("R5 short legacy verify", 4, 1'b1);
    endtask

    task automatic test_tie(input int n, input logic [1:0] code);
        bit found = 1'b0;
        fill(n, code);
        for (int a = 0; a < 256 && !found; a++) begin
            for (int b = 0; b < 256 && !found; b++) begin
                pkt[n-3] = 8'(a); pkt[n-2] = 8'(b);
                if (n == 3 + 1) pkt[0][7:6] = code;
                if (m_crc(n - 1) == m_xor(n - 1)) found = 1'b1;
            end
        end
        check("R4 collision found", {7'd0, found}, 8'd1);
        feed(n - 1, 1'b0, 1'b0);
        expect_res("R4 tie-break", n, 1'b0);
        pkt[n-1] = m_cur(n - 1, n == 4);
        feed(n, 1'b1, 1'b0);
        check("R4 adjusted accepted", {7'd0, current_ok}, 8'd1);
    endtask

    task automatic test_restart();
        fill(8, 2'b01);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_start = (i == 0); byte_last = 1'b0;
            byte_data = 8'($urandom); verify_mode = 1'b0;
        end
        feed(7, 1'b0, 1'b0);
        expect_res("R8 restart", 8, 1'b0);
    endtask

    task automatic test_gaps();
        fill(16, 2'b10);
        pkt[15] = m_cur(15, 1'b0);
        feed(16, 1'b1, 1'b1);
        expect_res("R9 gapped verify", 16, 1'b1);
    endtask

    task automatic test_pulse();
        logic [7:0] v;
        fill(8, 2'b01);
        feed(7, 1'b0, 1'b0);
        v = chk_value;
        check("R11 done high", {7'd0, chk_done}, 8'd1);
        @(negedge clk);
        check("R11 done dropped", {7'd0, chk_done}, 8'd0);
        check("R11 value held", chk_value, v);
        byte_valid = 1'b0; byte_data = 8'h5A;
        repeat (2) @(negedge clk);
        check("R11 value still held", chk_value, v);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        test_reset();
        test_generate(8, 2'b01);
        test_generate(16, 2'b10);
        test_generate(32, 2'b11);
        test_verify_large(8, 2'b01);
        test_verify_large(32, 2'b11);
        test_short();
        test_tie(8, 2'b01);
        test_tie(4, 2'b00);
        test_restart();
        test_gaps();
        test_pulse();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule